// File: doc/BRIEF.md
# Multi-Mode Configurable Function Generator Pair

This block holds two 16-bit storage cells, called F and G, that sit side by side as one slice pair. Each cell keeps its own sixteen bits and reads them through the same 4-bit address. A per-cell mode input decides what those bits are. In one mode they are the truth table of a 4-input Boolean function. In another they are a 16-stage shift register with a selectable output tap. In the third they are a 16-entry, 1-bit-wide RAM with synchronous writes.

The contents are configuration. A per-cell serial load port fills them after fabrication, so the function each cell computes is chosen at run time. A serial cascade output carries bit 15 of each cell. With the default chaining option, G's shift input takes F's cascade output, so the pair acts as one 32-stage shift chain. The stored bits survive a mode change, so data written in one mode can be read in any other.

Top module: `fgen_slice_pair`

## Requirements
- R1: An asserted reset (rst_n low) clears all 16 bits of both cells to zero. The internal release of reset follows the rising rst_n after two clock edges.
- R2: In every mode, dout[k] is combinationally equal to stored bit number addr[k] of cell k, where addr[k] is read as an unsigned index (addr[k][0] is the LSB). The mode encoding is 0 = look-up table, 1 = shift register, 2 = RAM, 3 = reserved.
- R3: In look-up-table mode (0) and in reserved mode (3), the data input and wen have no effect on the stored bits.
- R4: While cfg_en[k] is high, each rising edge moves every bit of cell k up one position and puts cfg_bit[k] into bit 0. After 16 load cycles, the first bit loaded is in bit 15, so the bits load MSB first.
- R5: A cycle with cfg_en[k] high performs only the configuration shift, whatever the mode, wen[k] and din[k] are.
- R6: In shift mode (1), a rising edge with wen[k] high moves every bit up one position and puts the cell's shift input into bit 0. The shift input of F is din[0].
- R7: cas_out[k] always equals bit 15 of cell k.
- R8: In RAM mode (2), a rising edge with wen[k] high writes din[k] into bit addr[k] and leaves the other 15 bits unchanged. The written value is readable on dout[k] at once through the asynchronous read.
- R9: A change of mode leaves the stored bits unchanged.
- R10: The two cells keep independent contents. When CHAIN_SHIFT is 1 (the default), G's shift input in shift mode is F's cas_out, and din[1] is not used for shifting.
- R11: In shift or RAM mode with wen[k] low and cfg_en[k] low, the bits of cell k do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 per cell (4) | Mode of each cell: 0 table, 1 shift, 2 RAM, 3 reserved |
| addr | input | 4 per cell (8) | Read index, which is also the RAM write index |
| din | input | 2 | Data bit for RAM writes, and the shift input of F |
| wen | input | 2 | Write or shift enable of each cell |
| cfg_en | input | 2 | Enable for the serial configuration load |
| cfg_bit | input | 2 | Serial configuration data bit |
| dout | output | 2 | Combinational read of the addressed bit |
| cas_out | output | 2 | Bit 15 of each cell |

## Verification
The assertions check the storage update on every cycle:
- the configuration shift and its priority over other operations,
- the held contents in table, reserved and idle cycles,
- the shift-register step,
- the RAM write to the addressed bit.

Some behaviour only the bench scenarios can show:
- MSB-first ordering over a whole 16-bit load, seen through address sweeps;
- the tap selection and the asynchronous read-after-write;
- the F-to-G cascade chaining;
- contents kept across mode changes;
- the independence of the two cells.

// File: rtl/fgen_pkg.sv
package fgen_pkg;
  typedef enum logic [1:0] {
    MODE_TABLE = 2'd0,
    MODE_SHIFT = 2'd1,
    MODE_RAM   = 2'd2,
    MODE_RSVD  = 2'd3
  } fgen_mode_t;
endpackage

// File: rtl/fgen_rst_sync.sv
module fgen_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fgen_store.sv
module fgen_store
  import fgen_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fgen_mode_t        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  input  logic              sin,
  input  logic              wen,
  input  logic              cfg_en,
  input  logic              cfg_bit,
  output logic [DEPTH-1:0]  bits
);
  logic [DEPTH-1:0] bits_q;
  logic [DEPTH-1:0] bits_d;
  logic             upd;

  always_comb begin
    bits_d = bits_q;
    upd    = 1'b0;
    if (cfg_en) begin
      bits_d = {bits_q[DEPTH-2:0], cfg_bit};
      upd    = 1'b1;
    end else if (wen) begin
      unique case (mode)
        MODE_SHIFT: begin
          bits_d = {bits_q[DEPTH-2:0], sin};
          upd    = 1'b1;
        end
        MODE_RAM: begin
          bits_d[addr] = din;
          upd          = 1'b1;
        end
        default: upd = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   bits_q <= '0;
    else if (upd) bits_q <= bits_d;
  end

  assign bits = bits_q;

  // R4: configuration shift
  a_r4_cfg_shift: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (bits_q == {$past(bits_q[DEPTH-2:0]), $past(cfg_bit)}));

  // R5: configuration wins over write and shift
  a_r5_cfg_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && wen) |=> (bits_q[0] == $past(cfg_bit)));

  // R3: table and reserved modes hold contents
  a_r3_table_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && (mode == MODE_TABLE || mode == MODE_RSVD)) |=> $stable(bits_q));

  // R11: idle cycles hold contents
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !wen) |=> $stable(bits_q));

  // R6: shift step
  a_r6_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && wen && mode == MODE_SHIFT)
      |=> (bits_q == {$past(bits_q[DEPTH-2:0]), $past(sin)}));

  // R8: RAM write lands at the address
  a_r8_ram_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && wen && mode == MODE_RAM)
      |=> (bits_q[$past(addr)] == $past(din)));
endmodule

// File: rtl/fgen_cell.sv
module fgen_cell
  import fgen_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  input  logic              sin,
  input  logic              wen,
  input  logic              cfg_en,
  input  logic              cfg_bit,
  output logic              dout,
  output logic              cas_out
);
  logic [DEPTH-1:0] bits;
  fgen_mode_t       mode_e;

  assign mode_e = fgen_mode_t'(mode);

  fgen_store #(.ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_e),
    .addr    (addr),
    .din     (din),
    .sin     (sin),
    .wen     (wen),
    .cfg_en  (cfg_en),
    .cfg_bit (cfg_bit),
    .bits    (bits)
  );

  assign dout    = bits[addr];
  assign cas_out = bits[DEPTH-1];
endmodule

// File: rtl/fgen_slice_pair.sv
module fgen_slice_pair #(
  parameter int NCELL       = 2,
  parameter int ADDR_W      = 4,
  parameter bit CHAIN_SHIFT = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NCELL-1:0][1:0]        mode,
  input  logic [NCELL-1:0][ADDR_W-1:0] addr,
  input  logic [NCELL-1:0]             din,
  input  logic [NCELL-1:0]             wen,
  input  logic [NCELL-1:0]             cfg_en,
  input  logic [NCELL-1:0]             cfg_bit,
  output logic [NCELL-1:0]             dout,
  output logic [NCELL-1:0]             cas_out
);
  logic             rst_int_n;
  logic [NCELL-1:0] sin;

  fgen_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  for (genvar k = 0; k < NCELL; k++) begin : g_cell
    if (CHAIN_SHIFT && k > 0) begin : g_chain
      assign sin[k] = cas_out[k-1];
    end else begin : g_local
      assign sin[k] = din[k];
    end

    fgen_cell #(.ADDR_W(ADDR_W)) u_cell (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .mode    (mode[k]),
      .addr    (addr[k]),
      .din     (din[k]),
      .sin     (sin[k]),
      .wen     (wen[k]),
      .cfg_en  (cfg_en[k]),
      .cfg_bit (cfg_bit[k]),
      .dout    (dout[k]),
      .cas_out (cas_out[k])
    );
  end
endmodule

// File: tb/fgen_slice_pair_tb.sv
`timescale 1ns/1ps
module fgen_slice_pair_tb;
  logic            clk;
  logic            rst_n;
  logic [1:0][1:0] mode;
  logic [1:0][3:0] addr;
  logic [1:0]      din, wen, cfg_en, cfg_bit;
  logic [1:0]      dout, cas_out;

  int checks;
  int failures;
  bit done;
  logic [15:0] exp_b [2];

  fgen_slice_pair u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .din(din),
    .wen(wen), .cfg_en(cfg_en), .cfg_bit(cfg_bit), .dout(dout), .cas_out(cas_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] b, input logic [1:0] m,
      input logic [3:0] a, input logic d, input logic s, input logic w,
      input logic c, input logic cb);
    logic [15:0] r;
    r = b;
    if (c) r = {b[14:0], cb};
    else if (w && m == 2'd1) r = {b[14:0], s};
    else if (w && m == 2'd2) r[a] = d;
    return r;
  endfunction

  task automatic step();
    logic [15:0] n0, n1;
    n0 = nxt(exp_b[0], mode[0], addr[0], din[0], din[0], wen[0], cfg_en[0], cfg_bit[0]);
    n1 = nxt(exp_b[1], mode[1], addr[1], din[1], exp_b[0][15], wen[1], cfg_en[1], cfg_bit[1]);
    @(posedge clk); #1;
    exp_b[0] = n0;
    exp_b[1] = n1;
  endtask

  task automatic read_all(input int k, output logic [15:0] v);
    wen = 2'b00; cfg_en = 2'b00;
    for (int i = 0; i < 16; i++) begin
      addr[k] = i[3:0];
      #4;
      v[i] = dout[k];
    end
  endtask

  task automatic check_both(input string req);
    logic [15:0] v;
    read_all(0, v); check({req, " F"}, v, exp_b[0]);
    read_all(1, v); check({req, " G"}, v, exp_b[1]);
    check({req, " cascade R7"}, {14'd0, cas_out}, {14'd0, exp_b[1][15], exp_b[0][15]});
  endtask

  task automatic t_reset();
    logic [15:0] v;
    exp_b[0] = '0; exp_b[1] = '0;
    read_all(0, v); check("R1 reset F", v, 16'h0000);
    read_all(1, v); check("R1 reset G", v, 16'h0000);
    check("R1 cascade", {14'd0, cas_out}, 16'h0000);
  endtask

  task automatic t_config(input logic [15:0] vf, input logic [15:0] vg);
    for (int i = 15; i >= 0; i--) begin
      cfg_en = 2'b11; cfg_bit = {vg[i], vf[i]}; step();
    end
    cfg_en = 2'b00;
    check("R4 msb-first F", exp_b[0], vf);
    check("R4 msb-first G", exp_b[1], vg);
    check_both("R4 R2 R10 load");
  endtask

  task automatic t_table_ignore();
    mode[0] = 2'd0; mode[1] = 2'd3; din = 2'b11; addr[0] = 4'd1; addr[1] = 4'd2;
    repeat (3) begin wen = 2'b11; step(); end
    wen = 2'b00;
    check_both("R3 table/reserved ignore");
  endtask

  task automatic t_priority();
    mode[0] = 2'd2; mode[1] = 2'd1; wen = 2'b11; din = 2'b11; addr = '0;
    cfg_en = 2'b11; cfg_bit = 2'b00; step();
    cfg_en = 2'b00; wen = 2'b00;
    check("R5 priority F bit0", {15'd0, exp_b[0][0]}, 16'h0000);
    check_both("R5 priority");
  endtask

  task automatic t_shift();
    logic [15:0] pat;
    pat = 16'hBEEF;
    mode[0] = 2'd1; mode[1] = 2'd1;
    for (int i = 0; i < 7; i++) begin
      wen = 2'b11; din = {1'b0, pat[i]}; step();
    end
    wen = 2'b00;
    check_both("R6 R10 shift chain");
    addr[0] = 4'd5; addr[1] = 4'd0; #1;
    check("R6 tap F", {15'd0, dout[0]}, {15'd0, exp_b[0][5]});
    check("R10 G fed by F", {15'd0, dout[1]}, {15'd0, exp_b[1][0]});
    repeat (3) step();
    check_both("R11 shift idle hold");
  endtask

  task automatic t_ram();
    mode[0] = 2'd2; mode[1] = 2'd2;
    addr[0] = 4'd3;  addr[1] = 4'd15; din = {~exp_b[1][15], ~exp_b[0][3]};
    wen = 2'b11; step(); wen = 2'b00; #1;
    check("R8 read-after-write F", {15'd0, dout[0]}, {15'd0, exp_b[0][3]});
    check("R8 read-after-write G", {15'd0, dout[1]}, {15'd0, exp_b[1][15]});
    addr[0] = 4'd12; addr[1] = 4'd7; din = 2'b10;
    wen = 2'b11; step(); wen = 2'b00;
    check_both("R8 ram writes");
  endtask

  task automatic t_mode_change();
    mode[0] = 2'd0; mode[1] = 2'd1; step();
    mode[0] = 2'd3; mode[1] = 2'd0; step();
    check_both("R9 mode change");
  endtask

  initial begin
    checks = 0; failures = 0; done = 0;
    rst_n = 1'b0; mode = '0; addr = '0; din = '0; wen = '0; cfg_en = '0; cfg_bit = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_config(16'hA5C3, 16'h0F69);
    t_table_ignore();
    t_priority();
    t_shift();
    t_ram();
    t_mode_change();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule